// File: doc/BRIEF.md
# Banked Programmable Interrupt Controller

The controller gathers a wide vector of interrupt lines, split into banks of 32, and turns each bank into a single cascade request for a parent controller. Every line can be programmed to trigger on a high level, a low level, a rising edge or a falling edge. Edge events are caught and held until software acknowledges them. Software can also raise a line by hand. A mask decides whether a pending line reaches the bank's status. For each bank the controller also reports the number of the highest pending, unmasked line, so the handler can dispatch that line without scanning.

Raw inputs are taken through a two-flop synchroniser before any detection. Software reaches the registers over a simple valid/ready register bus with byte addresses. Each bank occupies a 24-byte window, and the window of bank b starts at b*24. The global number of a line is bank*32 plus its bit position.

Top module: `pic_top`

## Requirements
- R1: After reset, every ENABLE register is 0, every POLARITY register is all ones, every EDGE register is 0, no latched state exists, every STATUS reads 0, every cascade_o bit is 0 and every top_idx_o field is 0.
- R2: Bank b decodes byte addresses b*24 to b*24+23, with word offsets STATUS 0x00, ENABLE 0x04, SET 0x08, CLEAR 0x0C, POLARITY 0x10 and EDGE 0x14. ENABLE, POLARITY and EDGE read back the value last written. SET and CLEAR read as 0. Addresses at or above NB*24 read as 0.
- R3: A line's trigger is set by its EDGE and POLARITY bits: (0,1) level high, (0,0) level low, (1,1) rising edge, (1,0) falling edge. In level mode the line is pending while the synchronised input equals its POLARITY bit.
- R4: In edge mode a detected transition sets a sticky pending bit. The bit stays set until a 1 is written to that line's bit in CLEAR. A 0 written to CLEAR leaves the bit unchanged.
- R5: Writing a 1 to a line's bit in SET makes the line pending in any mode. The pending state stays until it is cleared through CLEAR.
- R6: STATUS bit n equals pending AND ENABLE bit n. An edge event that arrives while the line is masked is still latched, and it shows up in STATUS once the line is enabled.
- R7: cascade_o[b] is 1 exactly when bank b's STATUS is nonzero.
- R8: top_idx_o[b*5 +: 5] holds the highest set bit position of bank b's STATUS, and 0 when STATUS is 0.
- R9: bus_ready_o is always 1. For every accepted read, bus_rvalid_o is high with the read data on the next cycle. bus_rvalid_o is low otherwise.
- R10: A write to a STATUS offset has no effect on any register or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NB*32 | Raw interrupt lines; line g is bank g/32, bit g%32 |
| bus_valid_i | input | 1 | Register access request |
| bus_ready_o | output | 1 | Request accepted (always high) |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | AW | Byte address, AW = clog2(NB*24) |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| bus_rdata_o | output | 32 | Read data |
| cascade_o | output | NB | Per-bank request to the parent |
| top_idx_o | output | NB*5 | Per-bank index of the highest pending, enabled line |

## Verification
Assertions check four things on every cycle. A SET write leaves its bits latched. A CLEAR write removes its bits unless a new edge arrives in the same cycle. The reported index always points at the highest set STATUS bit. Read responses follow accepted reads exactly. Trigger decoding across all four modes, the synchroniser latency, late enabling of a masked edge, and the address windows, including out-of-range and STATUS writes, can only be shown by the bench. It drives input patterns against a reference model and compares STATUS, cascade and index for every bank.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 32;
  localparam int STRIDE = 24;
  localparam int IW     = $clog2(LINES);

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_ENABLE = 3'd1,
    REG_SET    = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_POL    = 3'd4,
    REG_EDGE   = 3'd5
  } reg_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pic_bank.sv
module pic_bank import pic_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] irq_i,
  input  logic             wr_i,
  input  logic [2:0]       word_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             cascade_o,
  output logic [IW-1:0]    idx_o
);
  logic [LINES-1:0] en_q, pol_q, edg_q, lat_q, prev_q;
  logic [LINES-1:0] s, ev, lvl, pend, status, set_m, clr_m, lat_d;

  pic_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (s)
  );

  assign set_m = (wr_i && word_i == REG_SET)   ? wdata_i : '0;
  assign clr_m = (wr_i && word_i == REG_CLEAR) ? wdata_i : '0;

  // edge event: transition toward the polarity level
  assign ev    = edg_q & ((pol_q & s & ~prev_q) | (~pol_q & ~s & prev_q));
  assign lat_d = (lat_q & ~clr_m) | ev | set_m;
  assign lvl   = ~(s ^ pol_q);
  assign pend  = lat_q | (~edg_q & lvl);
  assign status = pend & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '1;
      edg_q  <= '0;
      lat_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= s;
      lat_q  <= lat_d;
      if (wr_i && word_i == REG_ENABLE) en_q  <= wdata_i;
      if (wr_i && word_i == REG_POL)    pol_q <= wdata_i;
      if (wr_i && word_i == REG_EDGE)   edg_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (word_i)
      REG_STATUS: rdata_o = status;
      REG_ENABLE: rdata_o = en_q;
      REG_POL:    rdata_o = pol_q;
      REG_EDGE:   rdata_o = edg_q;
      default:    rdata_o = '0;
    endcase
  end

  // highest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LINES; i++)
      if (status[i]) idx_o = IW'(i);
  end

  assign cascade_o = |status;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == REG_SET) |=> ((lat_q & $past(wdata_i)) == $past(wdata_i))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word_i == REG_CLEAR) |=> ((lat_q & $past(wdata_i & ~ev)) == '0)); // R4
  AST_IDX_HIGHEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_o |-> ((status >> idx_o) == 32'd1)); // R8
  AST_CASCADE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_o |-> (en_q != '0)); // R6
endmodule

// File: rtl/pic_top.sv
module pic_top import pic_pkg::*; #(
  parameter int NB = 5,
  localparam int AW = $clog2(NB * STRIDE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB*32-1:0] irq_i,
  input  logic             bus_valid_i,
  output logic             bus_ready_o,
  input  logic             bus_write_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic             bus_rvalid_o,
  output logic [31:0]      bus_rdata_o,
  output logic [NB-1:0]    cascade_o,
  output logic [NB*IW-1:0] top_idx_o
);
  logic [NB-1:0] hit;
  logic [31:0]   bank_rdata [NB];
  logic [31:0]   rd_mux;

  assign bus_ready_o = 1'b1;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BASE = b * STRIDE;
    logic [AW-1:0] off;

    assign hit[b] = (bus_addr_i >= AW'(BASE)) && (bus_addr_i < AW'(BASE + STRIDE));
    assign off    = bus_addr_i - AW'(BASE);

    pic_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .irq_i    (irq_i[b*LINES +: LINES]),
      .wr_i     (bus_valid_i && bus_write_i && hit[b]),
      .word_i   (off[4:2]),
      .wdata_i  (bus_wdata_i),
      .rdata_o  (bank_rdata[b]),
      .cascade_o(cascade_o[b]),
      .idx_o    (top_idx_o[b*IW +: IW])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++)
      if (hit[b]) rd_mux = bank_rdata[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= bus_valid_i && !bus_write_i;
      if (bus_valid_i && !bus_write_i) bus_rdata_o <= rd_mux;
    end
  end

  AST_READ_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o); // R9
  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o); // R9
endmodule

// File: tb/tb_pic_top.sv
module tb_pic_top;
  localparam int NB = 5;
  localparam int AW = $clog2(NB * 24);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NB*32-1:0] irq = '0;
  logic             valid = 1'b0, write = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [31:0]      wdata = '0;
  logic             ready, rvalid;
  logic [31:0]      rdata;
  logic [NB-1:0]    cascade;
  logic [NB*5-1:0]  top_idx;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_en [NB], m_pol [NB], m_edg [NB], m_lat [NB];

  always #4 clk = ~clk;

  pic_top #(.NB(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_valid_i(valid), .bus_ready_o(ready), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .cascade_o(cascade), .top_idx_o(top_idx)
  );

  function automatic logic [31:0] exp_status(int b);
    logic [31:0] lin, lvl;
    lin = irq[b*32 +: 32];
    lvl = ~(lin ^ m_pol[b]);
    return (m_lat[b] | (~m_edg[b] & lvl)) & m_en[b];
  endfunction

  function automatic logic [4:0] exp_idx(logic [31:0] st);
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++) if (st[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [AW-1:0] a(int b, int w);
    return AW'(b * 24 + w * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] ad, logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = ad; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] ad, output logic [31:0] d);
    @(negedge clk);
    chk("R9 ready", {31'd0, ready}, 32'd1);
    valid = 1'b1; write = 1'b0; addr = ad;
    @(negedge clk);
    valid = 1'b0;
    chk("R9 rvalid", {31'd0, rvalid}, 32'd1);
    d = rdata;
    @(negedge clk);
    chk("R9 rvalid drop", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic drive_irq(logic [NB*32-1:0] nv);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] o, n, ev;
      o = irq[b*32 +: 32];
      n = nv[b*32 +: 32];
      ev = m_edg[b] & ((m_pol[b] & n & ~o) | (~m_pol[b] & ~n & o));
      m_lat[b] |= ev;
    end
    @(negedge clk);
    irq = nv;
    settle();
  endtask

  task automatic write_reg(int b, int w, logic [31:0] d);
    wr(a(b, w), d);
    case (w)
      1: m_en[b] = d;
      2: m_lat[b] |= d;
      3: m_lat[b] &= ~d;
      4: m_pol[b] = d;
      5: m_edg[b] = d;
      default: ;
    endcase
    settle();
  endtask

  task automatic check_all(string req);
    logic [31:0] d, st;
    for (int b = 0; b < NB; b++) begin
      st = exp_status(b);
      rd(a(b, 0), d);
      chk({req, " status"}, d, st);
      chk("R7 cascade", {31'd0, cascade[b]}, {31'd0, |st});
      chk("R8 index", {27'd0, top_idx[b*5 +: 5]}, {27'd0, exp_idx(st)});
    end
  endtask

  initial begin
    logic [31:0] d;
    int unused;
    unused = $urandom(32'h5EED_0042);
    for (int b = 0; b < NB; b++) begin
      m_en[b] = '0; m_pol[b] = '1; m_edg[b] = '0; m_lat[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset values
    chk("R1 cascade", {27'd0, cascade}, 32'd0);
    chk("R1 index", {{(32-NB*5){1'b0}}, top_idx}, 32'd0);
    for (int b = 0; b < NB; b++) begin
      rd(a(b, 1), d); chk("R1 enable", d, 32'd0);
      rd(a(b, 4), d); chk("R1 polarity", d, 32'hFFFF_FFFF);
      rd(a(b, 5), d); chk("R1 edge", d, 32'd0);
    end
    check_all("R1");

    // R2 address map
    write_reg(3, 1, 32'hA5A5_0F0F);
    rd(a(3, 1), d); chk("R2 enable rw", d, 32'hA5A5_0F0F);
    rd(a(2, 1), d); chk("R2 neighbour", d, 32'd0);
    write_reg(4, 4, 32'h1234_5678);
    rd(a(4, 4), d); chk("R2 polarity rw", d, 32'h1234_5678);
    write_reg(4, 4, 32'hFFFF_FFFF);
    rd(a(1, 2), d); chk("R2 set reads 0", d, 32'd0);
    rd(a(1, 3), d); chk("R2 clear reads 0", d, 32'd0);
    rd(AW'(NB * 24), d); chk("R2 out of range", d, 32'd0);
    write_reg(3, 1, 32'd0);

    // R3 four trigger modes on bank 1 line 7
    write_reg(1, 1, 32'h0000_0080);
    drive_irq(irq | (160'd1 << 39)); check_all("R3 level high");
    write_reg(1, 4, 32'hFFFF_FF7F); check_all("R3 level low");
    drive_irq(irq & ~(160'd1 << 39)); check_all("R3 level low asserted");
    write_reg(1, 5, 32'h0000_0080); write_reg(1, 4, 32'hFFFF_FFFF);
    drive_irq(irq | (160'd1 << 39)); check_all("R3 rising");
    drive_irq(irq & ~(160'd1 << 39)); check_all("R4 sticky after drop");
    write_reg(1, 3, 32'h0000_0000); check_all("R4 clear zero");
    write_reg(1, 3, 32'h0000_0080); check_all("R4 clear");
    write_reg(1, 4, 32'hFFFF_FF7F);
    drive_irq(irq | (160'd1 << 39)); check_all("R3 falling no event");
    drive_irq(irq & ~(160'd1 << 39)); check_all("R3 falling");
    write_reg(1, 3, 32'h0000_0080);

    // R6 masked edge then enable
    write_reg(0, 5, 32'h8000_0000);
    drive_irq(irq | (160'd1 << 31)); check_all("R6 masked");
    write_reg(0, 1, 32'h8000_0001); check_all("R6 late enable");

    // R5 software set in level mode, then clear
    write_reg(0, 2, 32'h0000_0001); check_all("R5 set");
    write_reg(0, 3, 32'h8000_0001); check_all("R5 cleared");

    // R10 status write ignored
    write_reg(2, 1, 32'hFFFF_FFFF);
    wr(a(2, 0), 32'hFFFF_FFFF); settle();
    check_all("R10 status write");
    rd(a(2, 1), d); chk("R10 enable kept", d, 32'hFFFF_FFFF);

    // constrained random
    for (int it = 0; it < 250; it++) begin
      int op, b;
      op = int'($urandom_range(0, 5));
      b  = int'($urandom_range(0, NB - 1));
      case (op)
        0: drive_irq({$urandom(), $urandom(), $urandom(), $urandom(), $urandom()});
        1: write_reg(b, 1, $urandom());
        2: write_reg(b, 2, $urandom() & $urandom() & $urandom());
        3: write_reg(b, 3, $urandom());
        4: write_reg(b, 4, $urandom());
        default: write_reg(b, 5, $urandom());
      endcase
      check_all("R3 R4 R5 R6 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule